// File: doc/BRIEF.md
# Dual-Strobe Up/Down Decade or Binary Counter

This block is a four-bit counter that has two count strobes instead of a direction pin. A rising edge on the up strobe adds one to the count. A rising edge on the down strobe subtracts one. Each strobe counts only while the other strobe rests high. A parameter sets the count range to ten states (decade) or sixteen states (binary). A level-sensitive, active-high clear forces the count to zero. An active-low load copies a four-bit data word into the count. Both act without any strobe edge, and clear wins over load.

The strobes are asynchronous to the system clock. Each passes through a two-flop synchronizer, and a rising-edge detector follows it. Two active-low flags support cascading. The carry flag is low while the count sits at its top value and the up strobe is low. The borrow flag is low while the count is zero and the down strobe is low. Each flag therefore follows the low phase of the strobe that is about to wrap the count. To form a wider counter, connect carry to the next stage's up strobe and borrow to its down strobe.

Top module: `updn_strobe_counter`

## Requirements
- R1: A rising edge on `up_strobe` while `dn_strobe` stays high adds one to `count`.
- R2: A rising edge on `dn_strobe` while `up_strobe` stays high subtracts one from `count`.
- R3: No count occurs when a strobe rises while the other strobe is low, or when both strobes rise in the same system clock cycle.
- R4: While `clear` is high, `count` is forced to 0, whatever the values of `load_n` and the strobes.
- R5: While `load_n` is low and `clear` is low, `count` takes `din`, and strobe edges have no effect.
- R6: With DECADE=1, counting up from 9 gives 0, and counting down from 0 gives 9.
- R7: With DECADE=0, counting up from 15 gives 0, and counting down from 0 gives 15.
- R8: `carry_n` is low exactly when `count` equals the top value (9 in decade mode, 15 in binary mode) and the synchronized up strobe is low.
- R9: `borrow_n` is low exactly when `count` is 0 and the synchronized down strobe is low.
- R10: In decade mode, a loaded value from 10 to 15 counts up by one per edge, goes from 15 to 0 without a carry pulse, and counts down by one.
- R11: A strobe edge changes `count` on the third system clock edge after the strobe changes. The clear and load levels take effect on the next clock edge.
- R12: While `rst_n` is low, `count` is 0 and `carry_n` and `borrow_n` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the strobes and updates the count |
| rst_n | input | 1 | Asynchronous system reset, active low |
| up_strobe | input | 1 | Count-up strobe; a rising edge counts up; rests high |
| dn_strobe | input | 1 | Count-down strobe; a rising edge counts down; rests high |
| load_n | input | 1 | Parallel load, active low |
| clear | input | 1 | Clear to zero, active high, takes priority over load |
| din | input | WIDTH | Value to load |
| count | output | WIDTH | Counter value |
| carry_n | output | 1 | Active-low pulse when counting up past the top value |
| borrow_n | output | 1 | Active-low pulse when counting down past zero |

## Verification
A decade instance and a binary instance receive the same stimulus, so one sequence of edges shows how the two modulus variants differ at their wraps. Single clean up and down pulses test the direction decode. A strobe that rises while its partner is low, and two strobes that rise together, show whether the design really requires the other input to be high. Loading each of the values 10 to 15 into the decade instance tests the escape from illegal states. A long random mix of clear, load and strobe operations tests the priority ordering. Two decade instances wired carry-to-up and borrow-to-down count through 0 to 99 and back, which shows that the flag pulses have the correct phase for ripple cascading.

// File: rtl/updn_pkg.sv
package updn_pkg;

    typedef enum logic [2:0] {
        OP_HOLD  = 3'd0,
        OP_CLEAR = 3'd1,
        OP_LOAD  = 3'd2,
        OP_UP    = 3'd3,
        OP_DOWN  = 3'd4
    } updn_op_e;

    // Priority: clear, then load, then a lone strobe edge with its partner high.
    function automatic updn_op_e pick_op(
        input logic clr,
        input logic ld_n,
        input logic up_rise,
        input logic dn_rise,
        input logic up_lvl,
        input logic dn_lvl
    );
        if (clr)                                  return OP_CLEAR;
        if (!ld_n)                                return OP_LOAD;
        if (up_rise && !dn_rise && dn_lvl)        return OP_UP;
        if (dn_rise && !up_rise && up_lvl)        return OP_DOWN;
        return OP_HOLD;
    endfunction

endpackage

// File: rtl/updn_strobe_sync.sv
module updn_strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_in,
    output logic level,
    output logic rise
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_s;

    sync_s s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.chain = {s_q.chain[STAGES-2:0], strobe_in};
        s_d.prev  = s_q.chain[STAGES-1];
    end

    // Idle level of a strobe is high, so reset to ones to avoid a false edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '1;
        else        s_q <= s_d;
    end

    assign level = s_q.chain[STAGES-1];
    assign rise  = level & ~s_q.prev;

    // R11: one edge of the strobe gives a single-cycle rise indication.
    a_r11_single_rise: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);

endmodule

// File: rtl/updn_count_core.sv
module updn_count_core
    import updn_pkg::*;
#(
    parameter int WIDTH  = 4,
    parameter bit DECADE = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             load_n,
    input  logic [WIDTH-1:0] din,
    input  logic             up_rise,
    input  logic             dn_rise,
    input  logic             up_lvl,
    input  logic             dn_lvl,
    output logic [WIDTH-1:0] cnt
);
    localparam logic [WIDTH-1:0] TOP = DECADE ? WIDTH'(9) : {WIDTH{1'b1}};
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    typedef struct packed {
        logic [WIDTH-1:0] cnt;
    } core_s;

    core_s    c_d, c_q;
    updn_op_e op;

    always_comb begin
        op  = pick_op(clear, load_n, up_rise, dn_rise, up_lvl, dn_lvl);
        c_d = c_q;
        unique case (op)
            OP_CLEAR: c_d.cnt = '0;
            OP_LOAD:  c_d.cnt = din;
            OP_UP:    c_d.cnt = (c_q.cnt == TOP) ? '0 : c_q.cnt + ONE;
            OP_DOWN:  c_d.cnt = (c_q.cnt == '0) ? TOP : c_q.cnt - ONE;
            default:  c_d.cnt = c_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign cnt = c_q.cnt;

    // R4: clear forces zero on the next edge
    a_r4_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (cnt == '0));
    // R5: load copies the data word
    a_r5_load_copy: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !load_n) |=> (cnt == $past(din)));
    // R3: no edge and no level command keeps the count
    a_r3_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && load_n && !up_rise && !dn_rise) |=> $stable(cnt));
    // R6/R7: wrap upward from the top value
    a_r6_up_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && load_n && up_rise && !dn_rise && dn_lvl && cnt == TOP) |=> (cnt == '0));
    // R6/R7: wrap downward from zero
    a_r6_down_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && load_n && dn_rise && !up_rise && up_lvl && cnt == '0) |=> (cnt == TOP));

endmodule

// File: rtl/updn_flag_gen.sv
module updn_flag_gen #(
    parameter int WIDTH  = 4,
    parameter bit DECADE = 1'b1
) (
    input  logic [WIDTH-1:0] cnt,
    input  logic             up_lvl,
    input  logic             dn_lvl,
    output logic             carry_n,
    output logic             borrow_n
);
    localparam logic [WIDTH-1:0] TOP = DECADE ? WIDTH'(9) : {WIDTH{1'b1}};

    // Flags follow the low phase of the strobe that will wrap the count.
    always_comb begin
        carry_n  = !((cnt == TOP) && !up_lvl);
        borrow_n = !((cnt == '0)  && !dn_lvl);
    end

endmodule

// File: rtl/updn_strobe_counter.sv
module updn_strobe_counter #(
    parameter int WIDTH       = 4,
    parameter bit DECADE      = 1'b1,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             up_strobe,
    input  logic             dn_strobe,
    input  logic             load_n,
    input  logic             clear,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] count,
    output logic             carry_n,
    output logic             borrow_n
);
    localparam int N_STROBES = 2;

    logic [N_STROBES-1:0] strobe_raw;
    logic [N_STROBES-1:0] strobe_lvl;
    logic [N_STROBES-1:0] strobe_rise;

    assign strobe_raw = {dn_strobe, up_strobe};

    for (genvar g = 0; g < N_STROBES; g++) begin : g_sync
        updn_strobe_sync #(.STAGES(SYNC_STAGES)) i_sync (
            .clk       (clk),
            .rst_n     (rst_n),
            .strobe_in (strobe_raw[g]),
            .level     (strobe_lvl[g]),
            .rise      (strobe_rise[g])
        );
    end

    updn_count_core #(.WIDTH(WIDTH), .DECADE(DECADE)) i_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (clear),
        .load_n  (load_n),
        .din     (din),
        .up_rise (strobe_rise[0]),
        .dn_rise (strobe_rise[1]),
        .up_lvl  (strobe_lvl[0]),
        .dn_lvl  (strobe_lvl[1]),
        .cnt     (count)
    );

    updn_flag_gen #(.WIDTH(WIDTH), .DECADE(DECADE)) i_flags (
        .cnt      (count),
        .up_lvl   (strobe_lvl[0]),
        .dn_lvl   (strobe_lvl[1]),
        .carry_n  (carry_n),
        .borrow_n (borrow_n)
    );

endmodule

// File: tb/test_updn_strobe_counter.sv
module test_updn_strobe_counter;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic up = 1'b1, dn = 1'b1, ld_n = 1'b1, clr = 1'b0;
    logic [3:0] din = 4'd0;
    logic cu = 1'b1, cd = 1'b1, cclr = 1'b0;

    logic [3:0] dec_cnt, bin_cnt, lo_cnt, hi_cnt;
    logic dec_c, dec_b, bin_c, bin_b, lo_c, lo_b, hi_c, hi_b;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;  // 125 MHz

    updn_strobe_counter #(.WIDTH(4), .DECADE(1'b1), .SYNC_STAGES(2)) i_updn_strobe_counter (
        .clk(clk), .rst_n(rst_n), .up_strobe(up), .dn_strobe(dn), .load_n(ld_n),
        .clear(clr), .din(din), .count(dec_cnt), .carry_n(dec_c), .borrow_n(dec_b));

    updn_strobe_counter #(.WIDTH(4), .DECADE(1'b0), .SYNC_STAGES(2)) i_bin (
        .clk(clk), .rst_n(rst_n), .up_strobe(up), .dn_strobe(dn), .load_n(ld_n),
        .clear(clr), .din(din), .count(bin_cnt), .carry_n(bin_c), .borrow_n(bin_b));

    updn_strobe_counter #(.WIDTH(4), .DECADE(1'b1), .SYNC_STAGES(2)) i_lo (
        .clk(clk), .rst_n(rst_n), .up_strobe(cu), .dn_strobe(cd), .load_n(1'b1),
        .clear(cclr), .din(4'd0), .count(lo_cnt), .carry_n(lo_c), .borrow_n(lo_b));

    updn_strobe_counter #(.WIDTH(4), .DECADE(1'b1), .SYNC_STAGES(2)) i_hi (
        .clk(clk), .rst_n(rst_n), .up_strobe(lo_c), .dn_strobe(lo_b), .load_n(1'b1),
        .clear(cclr), .din(4'd0), .count(hi_cnt), .carry_n(hi_c), .borrow_n(hi_b));

    typedef struct {
        int    dec, bin, casc;
        logic  dc, db, bc, bb;
        string tag;
    } exp_t;

    exp_t sb_q[$];
    int m_dec = 0, m_bin = 0, m_casc = 0;

    function automatic int dec_up(int c);   return (c == 9) ? 0 : (c + 1) % 16; endfunction
    function automatic int dec_dn(int c);   return (c == 0) ? 9 : c - 1;        endfunction
    function automatic int bin_up(int c);   return (c + 1) % 16;                endfunction
    function automatic int bin_dn(int c);   return (c + 15) % 16;               endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Monitor: pop expected items and compare with the outputs.
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            chk({e.tag, " dec count"}, int'(dec_cnt), e.dec);
            chk({e.tag, " bin count"}, int'(bin_cnt), e.bin);
            chk({e.tag, " R8 dec carry_n"}, int'(dec_c), int'(e.dc));
            chk({e.tag, " R9 dec borrow_n"}, int'(dec_b), int'(e.db));
            chk({e.tag, " R8 bin carry_n"}, int'(bin_c), int'(e.bc));
            chk({e.tag, " R9 bin borrow_n"}, int'(bin_b), int'(e.bb));
            chk({e.tag, " cascade value"}, int'(hi_cnt) * 10 + int'(lo_cnt), e.casc);
        end
    end

    task automatic settle();
        repeat (5) @(negedge clk);
    endtask

    task automatic push(input string tag);
        exp_t e;
        e.dec = m_dec; e.bin = m_bin; e.casc = m_casc;
        e.dc = !(m_dec == 9 && !up);
        e.db = !(m_dec == 0 && !dn);
        e.bc = !(m_bin == 15 && !up);
        e.bb = !(m_bin == 0 && !dn);
        e.tag = tag;
        sb_q.push_back(e);
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic pulse_up();
        up = 1'b0; settle(); push("R8 up low phase");
        up = 1'b1; settle();
        m_dec = dec_up(m_dec); m_bin = bin_up(m_bin);
        push("R1 R6 R7 R10 count up");
    endtask

    task automatic pulse_dn();
        dn = 1'b0; settle(); push("R9 down low phase");
        dn = 1'b1; settle();
        m_dec = dec_dn(m_dec); m_bin = bin_dn(m_bin);
        push("R2 R6 R7 R10 count down");
    endtask

    task automatic do_load(input int v);
        din = 4'(v); ld_n = 1'b0; settle();
        m_dec = v; m_bin = v; push("R5 load");
        ld_n = 1'b1; settle(); push("R5 hold after load");
    endtask

    task automatic do_clear();
        clr = 1'b1; settle();
        m_dec = 0; m_bin = 0; push("R4 clear");
        clr = 1'b0; settle();
    endtask

    task automatic casc_step(input bit go_up);
        if (go_up) begin cu = 1'b0; settle(); cu = 1'b1; m_casc = (m_casc + 1) % 100; end
        else       begin cd = 1'b0; settle(); cd = 1'b1; m_casc = (m_casc + 99) % 100; end
        repeat (9) @(negedge clk);
        push("R6 cascade step");
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : driver
        repeat (3) @(negedge clk);
        // R12: outputs during reset
        chk("R12 reset count", int'(dec_cnt), 0);
        chk("R12 reset carry_n", int'(dec_c), 1);
        chk("R12 reset borrow_n", int'(dec_b), 1);
        rst_n = 1'b1;
        settle();
        push("R12 after reset");

        pulse_up(); pulse_up(); pulse_dn();

        // R11: latency of a strobe edge
        up = 1'b0; settle(); up = 1'b1;
        repeat (2) @(negedge clk);
        chk("R11 no change after two edges", int'(bin_cnt), m_bin);
        @(negedge clk);
        m_dec = dec_up(m_dec); m_bin = bin_up(m_bin);
        chk("R11 change on third edge", int'(bin_cnt), m_bin);
        settle();

        // R11: load level acts on the next edge
        din = 4'd6; ld_n = 1'b0;
        @(negedge clk);
        chk("R11 load next edge", int'(bin_cnt), 6);
        ld_n = 1'b1; m_dec = 6; m_bin = 6; settle();

        // R3: both strobes rise together
        up = 1'b0; dn = 1'b0; settle(); push("R3 both low");
        up = 1'b1; dn = 1'b1; settle(); push("R3 both rise no count");

        // R3: up rises while down is low, then down rises with up high
        dn = 1'b0; settle(); up = 1'b0; settle();
        up = 1'b1; settle(); push("R3 up with down low");
        dn = 1'b1; settle();
        m_dec = dec_dn(m_dec); m_bin = bin_dn(m_bin);
        push("R2 down after blocked up");

        // R6/R7: wraps at the top and at zero
        do_load(9);  pulse_up();
        do_load(15); pulse_up();
        do_clear();  pulse_dn(); pulse_up();

        // R4: clear wins over load, then load takes over
        din = 4'd7; ld_n = 1'b0; clr = 1'b1; settle();
        m_dec = 0; m_bin = 0; push("R4 clear beats load");
        clr = 1'b0; settle();
        m_dec = 7; m_bin = 7; push("R5 load after clear");

        // R5: strobe edges ignored during load
        up = 1'b0; settle(); up = 1'b1; settle(); push("R5 up ignored in load");
        dn = 1'b0; settle(); dn = 1'b1; settle(); push("R5 down ignored in load");
        ld_n = 1'b1; settle();

        // R10: decade escape from 10..15
        for (int v = 10; v <= 15; v++) begin
            do_load(v);
            while (m_dec != 0) pulse_up();
        end
        do_load(12); pulse_dn();

        // Random mix
        for (int i = 0; i < 150; i++) begin
            int op;
            op = int'($urandom_range(0, 7));
            case (op)
                0:       do_clear();
                1, 2:    do_load(int'($urandom_range(0, 15)));
                3, 4, 5: pulse_up();
                default: pulse_dn();
            endcase
        end

        // Cascade through 0..99 and back
        cclr = 1'b1; settle(); cclr = 1'b0; m_casc = 0; settle();
        for (int i = 0; i < 100; i++) casc_step(1'b1);
        casc_step(1'b0);
        casc_step(1'b0);
        casc_step(1'b1);

        while (sb_q.size() > 0) @(negedge clk);
        @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule